// File: doc/BRIEF.md
# Multi-Lane Deskew Release Buffer

This block sits behind the per-lane word aligners of a multi-lane serial receiver. Each lane delivers one 32-bit word per link clock, and it raises a one-cycle start marker with its first aligned word. From that word on, the lane's words go into a private buffer. Lanes that arrive early hold more words than lanes that arrive late. When every enabled lane has arrived, the block waits for a release point that is set relative to the local multiframe counter. All lanes then start reading out in the same cycle, which removes the skew between lanes and makes the latency repeatable from one link start-up to the next.

The release point can be set three ways:
- At the multiframe boundary.
- A programmable number of link clocks before the boundary.
- At once after the last arrival, either because the offset is out of range or because a force bit is set.

The block reports the multiframe counter value at which the last lane arrived. It raises a sticky deskew error if the arrivals spread over a full multiframe period or more, or if a buffer overflows before release.

The controller is a state machine with five states:
- **S_IDLE**: no lane has arrived yet.
- **S_GATHER**: some enabled lanes have arrived and others are still missing.
- **S_HOLD**: all enabled lanes have arrived and the block waits for the release point.
- **S_STREAM**: lockstep readout.
- **S_FAULT**: a terminal error state.

Its transitions are:
- From S_IDLE, the first enabled arrival moves to S_GATHER. If that arrival completes the set, it moves straight to S_HOLD.
- From S_GATHER, the last missing arrival moves to S_HOLD. If the span counter reaches one period first, the block moves to S_FAULT.
- From S_HOLD, the release point moves to S_STREAM. A buffer overflow moves to S_FAULT.
- S_STREAM and S_FAULT are kept until reset.

Top module: `deskew_release_buffer`

## Requirements
- R1: All enabled lanes present their first stored word on `out_data` in the same cycle. `out_valid` rises one clock after the release cycle. The release cycle is the first cycle, at least one cycle after the last arrival cycle, in which the release condition of R2 to R5 holds.
- R2: With `release_offset` = 0 and `force_release` = 0, the release cycle is the first eligible cycle in which `lmfc_tick` is high. `lmfc_tick` is high exactly when `lmfc_count` = 0.
- R3: With `release_offset` = N, where 1 <= N <= LMFC_PERIOD-1, the release cycle is the first eligible cycle with `lmfc_count` = LMFC_PERIOD-N, that is N link clocks before the boundary.
- R4: With `release_offset` >= LMFC_PERIOD, the release cycle is the cycle right after the last arrival.
- R5: With `force_release` = 1, release happens as in R4 whatever the offset.
- R6: `arrival_count` is 0 until the last enabled lane arrives. From the next clock it holds the `lmfc_count` value of the last arrival cycle, until reset.
- R7: If an enabled lane arrives LMFC_PERIOD or more cycles after the first enabled lane, `deskew_err` rises one clock after the cycle that is LMFC_PERIOD cycles after the first arrival. This also happens if that lane is still missing at that point. No data is released.
- R8: Start markers and data on lanes with `lane_en` = 0 are ignored. They neither delay nor advance the release, and those lanes output zero.
- R9: If a lane buffer already holds BUF_DEPTH words and must take another word before release, `deskew_err` rises one clock after that cycle and no data is released.
- R10: After release, `out_valid` stays high every cycle. Each enabled lane outputs its stored words in arrival order, one per cycle, all lanes advancing together.
- R11: After reset, `out_valid`, `deskew_err`, `arrival_count` and `out_data` are all zero.
- R12: `deskew_err` is sticky until reset. While it is high, `out_valid` is low.
- R13: Lane words in `lane_data` that come before a lane's start marker are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_en | input | NUM_LANES | Per-lane enable mask (1 = lane takes part) |
| lane_start | input | NUM_LANES | One-cycle marker on each lane's first aligned word |
| lane_data | input | NUM_LANES*DATA_W | Per-lane words, lane i in bits [i*DATA_W +: DATA_W] |
| lmfc_count | input | $clog2(LMFC_PERIOD) | Local multiframe counter, 0 to LMFC_PERIOD-1 |
| lmfc_tick | input | 1 | High in the cycle where the multiframe counter is 0 |
| release_offset | input | OFFSET_W | Early-release distance in link clocks |
| force_release | input | 1 | Release as soon as the last lane arrives |
| out_data | output | NUM_LANES*DATA_W | Deskewed words, same packing as `lane_data` |
| out_valid | output | 1 | Deskewed words are valid |
| arrival_count | output | $clog2(LMFC_PERIOD) | Multiframe counter value at the last arrival |
| deskew_err | output | 1 | Sticky skew or overflow error |

## Verification
Some properties are checked on every cycle by the assertions:
- The error flag stays set once raised, and `out_valid` never coincides with it.
- Valid never drops once streaming has begun.
- The recorded arrival count stays frozen during streaming.
- The arrival mask only ever grows.
- The gather span counter stays bounded, and no buffer fills past its depth or is read while empty.
- A release with zero offset and no force always follows a boundary tick.

Other properties depend on arrival patterns, offsets and counter phases, so only the bench scenarios can show them:
- The exact release cycle for each offset mode.
- The arithmetic order of the released words.
- The captured arrival position.
- The exact cycle at which skew or overflow is flagged.
- That masked lanes have no effect.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    // Controller states of the release buffer.
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_GATHER = 3'd1,
        S_HOLD   = 3'd2,
        S_STREAM = 3'd3,
        S_FAULT  = 3'd4
    } dsk_state_e;

endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_q,
    output logic              ovf
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [FILL_W-1:0] fill;
    logic              wr_acc;

    // A write into a full buffer that is not drained in the same cycle is lost.
    assign ovf    = wr_en && !rd_en && (fill == FILL_W'(DEPTH));
    assign wr_acc = wr_en && !ovf;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            rd_q   <= '0;
        end else begin
            if (wr_acc) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= bump(rd_ptr);
                rd_q   <= mem[rd_ptr];
            end
            unique case ({wr_acc, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R9: occupancy never passes the configured depth
    a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    // R10: lockstep readout never pulls from an empty lane buffer
    a_r10_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (fill != '0));

endmodule

// File: rtl/dsk_release_point.sv
module dsk_release_point #(
    parameter int LMFC_PERIOD = 16,
    parameter int OFFSET_W    = 8
) (
    input  logic [OFFSET_W-1:0]            release_offset,
    input  logic                           force_release,
    input  logic [$clog2(LMFC_PERIOD)-1:0] lmfc_count,
    input  logic                           lmfc_tick,
    output logic                           hit,
    output logic                           immediate
);
    localparam int CNT_W = $clog2(LMFC_PERIOD);

    logic [31:0]      off_ext;
    logic [CNT_W-1:0] target;
    logic             out_of_range;

    always_comb begin
        off_ext      = 32'(release_offset);
        out_of_range = off_ext >= 32'(LMFC_PERIOD);
        target       = CNT_W'(32'(LMFC_PERIOD) - off_ext);
        immediate    = force_release || out_of_range;
        if (immediate) begin
            hit = 1'b1;
        end else if (release_offset == '0) begin
            hit = lmfc_tick;
        end else begin
            hit = (lmfc_count == target);
        end
    end

endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
    import deskew_pkg::*;
#(
    parameter int NUM_LANES   = 8,
    parameter int LMFC_PERIOD = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LANES-1:0]           lane_en,
    input  logic [NUM_LANES-1:0]           lane_start,
    input  logic [$clog2(LMFC_PERIOD)-1:0] lmfc_count,
    input  logic                           rel_hit,
    input  logic                           ovf_any,
    output logic [NUM_LANES-1:0]           arrived,
    output logic [NUM_LANES-1:0]           wr_go,
    output logic                           rd_go,
    output logic                           out_valid,
    output logic [$clog2(LMFC_PERIOD)-1:0] arrival_count,
    output logic                           deskew_err
);
    localparam int CNT_W  = $clog2(LMFC_PERIOD);
    localparam int SPAN_W = $clog2(LMFC_PERIOD + 1);

    dsk_state_e            state;
    dsk_state_e            nxt;
    logic [SPAN_W-1:0]     span;
    logic [NUM_LANES-1:0]  start_now;
    logic [NUM_LANES-1:0]  arrived_nxt;
    logic                  accepting;
    logic                  all_now;
    logic                  span_over;

    assign accepting   = (state == S_IDLE) || (state == S_GATHER);
    assign start_now   = accepting ? (lane_start & lane_en & ~arrived) : '0;
    assign arrived_nxt = arrived | start_now;
    assign all_now     = &(arrived_nxt | ~lane_en);
    assign span_over   = (span >= SPAN_W'(LMFC_PERIOD));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (|start_now) begin
                    nxt = all_now ? S_HOLD : S_GATHER;
                end
            end
            S_GATHER: begin
                if (ovf_any || span_over) begin
                    nxt = S_FAULT;
                end else if (all_now) begin
                    nxt = S_HOLD;
                end
            end
            S_HOLD: begin
                if (rel_hit) begin
                    nxt = S_STREAM;
                end else if (ovf_any) begin
                    nxt = S_FAULT;
                end
            end
            S_STREAM: begin
                if (ovf_any) begin
                    nxt = S_FAULT;
                end
            end
            S_FAULT: nxt = S_FAULT;
            default: nxt = S_FAULT;
        endcase
    end

    // Buffer strobes
    assign rd_go = ((state == S_HOLD) && rel_hit) || (state == S_STREAM);
    assign wr_go = (state == S_FAULT) ? '0 : (arrived | start_now);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Registered outputs and bookkeeping of arrivals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arrived       <= '0;
            span          <= '0;
            out_valid     <= 1'b0;
            arrival_count <= '0;
            deskew_err    <= 1'b0;
        end else begin
            if (accepting) begin
                arrived <= arrived_nxt;
            end
            if (state == S_IDLE && |start_now) begin
                span <= SPAN_W'(1);
            end else if (state == S_GATHER && !span_over) begin
                span <= span + 1'b1;
            end
            if (accepting && nxt == S_HOLD) begin
                arrival_count <= lmfc_count;
            end
            out_valid  <= rd_go && (nxt == S_STREAM);
            deskew_err <= (nxt == S_FAULT);
        end
    end

    // R7: the gather span counter is bounded by one multiframe period
    a_r7_span_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GATHER) |-> (span <= SPAN_W'(LMFC_PERIOD)));

    // R12: once flagged, the error holds
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_err |=> deskew_err);

    // R12: no valid data alongside the error
    a_r12_no_valid_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_err |-> !out_valid);

    // R10: streaming never pauses
    a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R6: the recorded arrival position is frozen while streaming
    a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> $stable(arrival_count));

    // R8: arrival marks only accumulate
    a_r8_arrivals_grow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((arrived & $past(arrived)) == $past(arrived)));

endmodule

// File: rtl/deskew_release_buffer.sv
module deskew_release_buffer #(
    parameter int NUM_LANES   = 8,
    parameter int DATA_W      = 32,
    parameter int LMFC_PERIOD = 16,
    parameter int BUF_DEPTH   = 2 * LMFC_PERIOD + 2,
    parameter int OFFSET_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LANES-1:0]              lane_en,
    input  logic [NUM_LANES-1:0]              lane_start,
    input  logic [NUM_LANES*DATA_W-1:0]       lane_data,
    input  logic [$clog2(LMFC_PERIOD)-1:0]    lmfc_count,
    input  logic                              lmfc_tick,
    input  logic [OFFSET_W-1:0]               release_offset,
    input  logic                              force_release,
    output logic [NUM_LANES*DATA_W-1:0]       out_data,
    output logic                              out_valid,
    output logic [$clog2(LMFC_PERIOD)-1:0]    arrival_count,
    output logic                              deskew_err
);
    logic [NUM_LANES-1:0] arrived;
    logic [NUM_LANES-1:0] wr_go;
    logic [NUM_LANES-1:0] lane_ovf;
    logic                 rd_go;
    logic                 rel_hit;
    logic                 rel_immediate;

    dsk_release_point #(
        .LMFC_PERIOD (LMFC_PERIOD),
        .OFFSET_W    (OFFSET_W)
    ) u_relpt (
        .release_offset (release_offset),
        .force_release  (force_release),
        .lmfc_count     (lmfc_count),
        .lmfc_tick      (lmfc_tick),
        .hit            (rel_hit),
        .immediate      (rel_immediate)
    );

    dsk_ctrl #(
        .NUM_LANES   (NUM_LANES),
        .LMFC_PERIOD (LMFC_PERIOD)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_en       (lane_en),
        .lane_start    (lane_start),
        .lmfc_count    (lmfc_count),
        .rel_hit       (rel_hit),
        .ovf_any       (|lane_ovf),
        .arrived       (arrived),
        .wr_go         (wr_go),
        .rd_go         (rd_go),
        .out_valid     (out_valid),
        .arrival_count (arrival_count),
        .deskew_err    (deskew_err)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [DATA_W-1:0] q;

        dsk_lane_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (BUF_DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_go[i]),
            .wr_data (lane_data[i*DATA_W +: DATA_W]),
            .rd_en   (rd_go && arrived[i]),
            .rd_q    (q),
            .ovf     (lane_ovf[i])
        );

        assign out_data[i*DATA_W +: DATA_W] = arrived[i] ? q : '0;
    end

    // R2: a zero-offset, unforced release always follows a boundary tick
    a_r2_boundary_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && $past(release_offset) == '0 && !$past(force_release))
        |-> $past(lmfc_tick));

    // R5: a forced release is never a deferred one
    a_r5_force_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        force_release |-> rel_immediate);

endmodule

// File: tb/deskew_release_buffer_tb.sv
module deskew_release_buffer_tb;
    localparam int LANES = 4;
    localparam int W     = 32;
    localparam int P     = 8;
    localparam int DEPTH = P + 2;
    localparam int CW    = 3;
    localparam int OW    = 8;
    localparam int NCYC  = 20;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [LANES-1:0]    lane_en;
    logic [LANES-1:0]    lane_start;
    logic [LANES*W-1:0]  lane_data;
    logic [CW-1:0]       lmfc_count;
    logic                lmfc_tick;
    logic [OW-1:0]       release_offset;
    logic                force_release;
    logic [LANES*W-1:0]  out_data;
    logic                out_valid;
    logic [CW-1:0]       arrival_count;
    logic                deskew_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int arr [LANES];

    always #4 clk = ~clk;

    deskew_release_buffer #(
        .NUM_LANES   (LANES),
        .DATA_W      (W),
        .LMFC_PERIOD (P),
        .BUF_DEPTH   (DEPTH),
        .OFFSET_W    (OW)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lane_en        (lane_en),
        .lane_start     (lane_start),
        .lane_data      (lane_data),
        .lmfc_count     (lmfc_count),
        .lmfc_tick      (lmfc_tick),
        .release_offset (release_offset),
        .force_release  (force_release),
        .out_data       (out_data),
        .out_valid      (out_valid),
        .arrival_count  (arrival_count),
        .deskew_err     (deskew_err)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n          = 1'b0;
        lane_start     = '0;
        lane_data      = '0;
        lmfc_count     = '0;
        lmfc_tick      = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_case(input string rel_tag, input logic [LANES-1:0] en,
                            input int off, input bit frc, input int ph);
        int mn = 1000;
        int last = -1;
        int rel = -1;
        int err_at = -1;
        int tgt;
        bit skew_bad;
        do_reset();
        lane_en        = en;
        release_offset = OW'(off);
        force_release  = frc;
        for (int i = 0; i < LANES; i++) begin
            if (en[i] && arr[i] >= 0) begin
                if (arr[i] < mn) mn = arr[i];
                if (arr[i] > last) last = arr[i];
            end
        end
        skew_bad = (last - mn) >= P;
        if (skew_bad) begin
            err_at = mn + P;
        end else begin
            if (frc || off >= P) begin
                rel = last + 1;
            end else begin
                tgt = (off == 0) ? 0 : P - off;
                for (int c = last + 1; c <= last + P; c++)
                    if (rel < 0 && ((c + ph) % P) == tgt) rel = c;
            end
            if (rel > mn + DEPTH) begin
                err_at = mn + DEPTH;
                rel    = -1;
            end
        end
        for (int c = 0; c <= NCYC; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int k = c - 1;
                bit vexp = (rel >= 0) && (k >= rel);
                bit eexp = (err_at >= 0) && (k >= err_at);
                int aexp = (!skew_bad && k >= last) ? ((last + ph) % P) : 0;
                check(out_valid == vexp, rel_tag, out_valid, vexp);
                check(deskew_err == eexp, skew_bad ? "R7/R12" : "R9/R12", deskew_err, eexp);
                check(arrival_count == CW'(aexp), "R6", arrival_count, aexp);
                for (int i = 0; i < LANES; i++) begin
                    logic [W-1:0] dexp;
                    dexp = (vexp && en[i]) ? {8'(i), 24'(k - rel)} : '0;
                    check(out_data[i*W +: W] == dexp,
                          !en[i] ? "R8" : (k == rel ? "R1" : "R10/R13"),
                          out_data[i*W +: W], dexp);
                end
            end
            if (c < NCYC) begin
                lmfc_count = CW'((c + ph) % P);
                lmfc_tick  = ((c + ph) % P) == 0;
                for (int i = 0; i < LANES; i++) begin
                    lane_start[i] = (arr[i] == c);
                    lane_data[i*W +: W] = (arr[i] >= 0 && c >= arr[i]) ?
                        {8'(i), 24'(c - arr[i])} : (32'hBAD0_0000 | 32'(c));
                end
            end
        end
    endtask

    initial begin
        lane_en = '1; release_offset = '0; force_release = 1'b0;
        do_reset();
        @(negedge clk);
        // R11: reset state
        check(out_valid == 1'b0, "R11", out_valid, 0);
        check(deskew_err == 1'b0, "R11", deskew_err, 0);
        check(arrival_count == '0, "R11", arrival_count, 0);
        check(out_data == '0, "R11", out_data, 0);

        arr = '{0, 2, 5, 3};  run_case("R2", 4'b1111, 0, 1'b0, 2);
        arr = '{1, 0, 2, 2};  run_case("R3", 4'b1111, 3, 1'b0, 0);
        arr = '{0, 1, 2, 3};  run_case("R3", 4'b1111, 7, 1'b0, 0);
        arr = '{3, 1, 0, 2};  run_case("R4", 4'b1111, 8, 1'b0, 0);
        arr = '{2, 1, 0, 3};  run_case("R4", 4'b1111, 200, 1'b0, 3);
        arr = '{0, 0, 6, 1};  run_case("R5", 4'b1111, 0, 1'b1, 5);
        arr = '{1, 9, 2, 0};  run_case("R8", 4'b0101, 1, 1'b0, 0);
        arr = '{0, 1, 2, 4};  run_case("R8", 4'b1000, 0, 1'b0, 0);
        arr = '{0, 7, 3, 3};  run_case("R7", 4'b1111, 8, 1'b0, 0);
        arr = '{0, 8, 1, 1};  run_case("R7", 4'b1111, 0, 1'b0, 0);
        arr = '{0, 7, 7, 7};  run_case("R9", 4'b1111, 0, 1'b0, 1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule